// File: doc/BRIEF.md
# Display Extension Register Port

This block is the register front end of a graphics adapter's display extension. A host reaches it through two strobed ports. It first writes an index, then reads or writes the register that the index selects through a data port. The block stores ten 16-bit mode registers: identifier, horizontal and vertical resolution, colour depth, enable, bank, virtual width and height, and the X and Y panning offsets. It drives every stored value to downstream display logic.

One index past the stored array has no storage behind it. Reading it returns the size of video memory in 64 KiB units, which comes from a parameter. The block also drives a bank mask derived from that size.

Setting a capability flag in the enable register changes three reads. The resolution and depth indices then return the largest values the adapter supports instead of their stored contents. Each data read places its result in a register on the next clock edge, and that value holds until the next read.

Top module: `disp_ext_regport`

## Requirements
- R1: While reset is asserted, and after it is released, the index is 0 and read data is 0. Every stored register is 0 except the identifier at index 0, which is 0xB0C5.
- R2: A pulse on `idx_we_i` loads the 16-bit index. A data access in the same cycle uses the index held before that edge.
- R3: A data write to any of indices 1 to 9 stores all 16 bits. The new value appears on the matching output after the next clock edge.
- R4: A data write to index 0 is accepted only when the value lies in 0xB0C0..0xB0C5. Any other value leaves the identifier unchanged.
- R5: Data writes to index 0xA or above change no stored register.
- R6: A pulse on `dat_re_i` returns the value at the current index on `dat_rdata_o` after the next edge. Without a read strobe, `dat_rdata_o` holds its value.
- R7: A read of index 0xA returns the video memory size divided by 65536.
- R8: A read of any index above 0xA returns 0.
- R9: When bit 1 of the enable register (index 4) is 1, reads of indices 1, 2 and 3 return 1024, 768 and 32. All other indices still return their stored values, and the stored contents are not changed.
- R10: `bank_mask_o` equals the memory size shifted right by 16, minus one.
- R11: Register order is fixed: 0 identifier, 1 X resolution, 2 Y resolution, 3 bits per pixel, 4 enable, 5 bank, 6 virtual width, 7 virtual height, 8 X offset, 9 Y offset. Each index drives its own output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| idx_we_i | input | 1 | Index write strobe |
| idx_wdata_i | input | 16 | Index value |
| dat_we_i | input | 1 | Data write strobe |
| dat_wdata_i | input | 16 | Data write value |
| dat_re_i | input | 1 | Data read strobe |
| dat_rdata_o | output | 16 | Registered read data |
| id_o | output | 16 | Identifier register |
| xres_o | output | 16 | X resolution |
| yres_o | output | 16 | Y resolution |
| bpp_o | output | 16 | Bits per pixel |
| enable_o | output | 16 | Enable register |
| bank_o | output | 16 | Bank register |
| virt_w_o | output | 16 | Virtual width |
| virt_h_o | output | 16 | Virtual height |
| xoff_o | output | 16 | X offset |
| yoff_o | output | 16 | Y offset |
| bank_mask_o | output | 16 | Bank mask derived from memory size |

## Verification
The hardest case to reach is the interaction between the capability flag and ordinary reads. The flag is itself a stored bit, and a sweep of arbitrary values through the data port sets and clears it as a side effect. The bench therefore writes a distinct pattern to every index, including 0xA, 0xFFFF and ID values inside and outside the legal range. After each write it reads back every index, and a running model predicts each read, including whether the three capped indices return their maximums.

// File: rtl/disp_ext_pkg.sv
package disp_ext_pkg;
  localparam int unsigned NUM_REGS = 10;
  localparam int unsigned IDX_MEMSZ = 10;
  localparam int unsigned CAPS_BIT = 1;
  localparam logic [15:0] ID_MIN = 16'hB0C0;
  localparam logic [15:0] ID_MAX = 16'hB0C5;
  localparam logic [15:0] ID_RESET = 16'hB0C5;

  typedef enum int unsigned {
    REG_ID     = 0,
    REG_XRES   = 1,
    REG_YRES   = 2,
    REG_BPP    = 3,
    REG_ENABLE = 4,
    REG_BANK   = 5,
    REG_VIRT_W = 6,
    REG_VIRT_H = 7,
    REG_XOFF   = 8,
    REG_YOFF   = 9
  } dx_reg_e;
endpackage

// File: rtl/disp_ext_regfile.sv
module disp_ext_regfile
  import disp_ext_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned IW = 16,
  parameter int unsigned NREGS = NUM_REGS
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [IW-1:0]           wr_idx_i,
  input  logic [DW-1:0]           wr_data_i,
  output logic [NREGS-1:0][DW-1:0] regs_o
);
  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    logic hit;
    logic [DW-1:0] q;
    if (i == REG_ID) begin : g_id
      // identifier only takes known values
      assign hit = wr_en_i && (wr_idx_i == IW'(i)) &&
                   (wr_data_i >= DW'(ID_MIN)) && (wr_data_i <= DW'(ID_MAX));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  q <= DW'(ID_RESET);
        else if (hit) q <= wr_data_i;
      end
    end else begin : g_plain
      assign hit = wr_en_i && (wr_idx_i == IW'(i));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  q <= '0;
        else if (hit) q <= wr_data_i;
      end
    end
    assign regs_o[i] = q;
  end
endmodule

// File: rtl/disp_ext_rdmux.sv
module disp_ext_rdmux
  import disp_ext_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned IW = 16,
  parameter int unsigned NREGS = NUM_REGS,
  parameter int unsigned CAP_XRES = 1024,
  parameter int unsigned CAP_YRES = 768,
  parameter int unsigned CAP_BPP = 32
) (
  input  logic [IW-1:0]            idx_i,
  input  logic [NREGS-1:0][DW-1:0] regs_i,
  input  logic [DW-1:0]            mem_units_i,
  output logic [DW-1:0]            rd_o
);
  logic caps;
  assign caps = regs_i[REG_ENABLE][CAPS_BIT];

  always_comb begin
    rd_o = '0;
    if (idx_i < IW'(NREGS)) begin
      rd_o = regs_i[idx_i[$clog2(NREGS)-1:0]];
      if (caps) begin
        if (idx_i == IW'(REG_XRES)) rd_o = DW'(CAP_XRES);
        if (idx_i == IW'(REG_YRES)) rd_o = DW'(CAP_YRES);
        if (idx_i == IW'(REG_BPP))  rd_o = DW'(CAP_BPP);
      end
    end else if (idx_i == IW'(IDX_MEMSZ)) begin
      rd_o = mem_units_i;
    end
  end
endmodule

// File: rtl/disp_ext_regport.sv
module disp_ext_regport
  import disp_ext_pkg::*;
#(
  parameter int unsigned VRAM_BYTES = 32'h0100_0000,
  parameter int unsigned CAP_XRES = 1024,
  parameter int unsigned CAP_YRES = 768,
  parameter int unsigned CAP_BPP = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        idx_we_i,
  input  logic [15:0] idx_wdata_i,
  input  logic        dat_we_i,
  input  logic [15:0] dat_wdata_i,
  input  logic        dat_re_i,
  output logic [15:0] dat_rdata_o,
  output logic [15:0] id_o,
  output logic [15:0] xres_o,
  output logic [15:0] yres_o,
  output logic [15:0] bpp_o,
  output logic [15:0] enable_o,
  output logic [15:0] bank_o,
  output logic [15:0] virt_w_o,
  output logic [15:0] virt_h_o,
  output logic [15:0] xoff_o,
  output logic [15:0] yoff_o,
  output logic [15:0] bank_mask_o
);
  localparam int unsigned DW = 16;
  localparam int unsigned IW = 16;
  localparam int unsigned MEM_UNITS = VRAM_BYTES >> 16;
  localparam logic [DW-1:0] MEM_UNITS_W = DW'(MEM_UNITS);
  localparam logic [DW-1:0] BANK_MASK = DW'(MEM_UNITS - 1);

  logic [IW-1:0] idx_q;
  logic [DW-1:0] rdata_q;
  logic [DW-1:0] rd_val;
  logic [NUM_REGS-1:0][DW-1:0] regs;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       idx_q <= '0;
    else if (idx_we_i) idx_q <= idx_wdata_i;
  end

  disp_ext_regfile #(.DW(DW), .IW(IW), .NREGS(NUM_REGS)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (dat_we_i),
    .wr_idx_i (idx_q),
    .wr_data_i(dat_wdata_i),
    .regs_o   (regs)
  );

  disp_ext_rdmux #(
    .DW(DW), .IW(IW), .NREGS(NUM_REGS),
    .CAP_XRES(CAP_XRES), .CAP_YRES(CAP_YRES), .CAP_BPP(CAP_BPP)
  ) u_rdmux (
    .idx_i      (idx_q),
    .regs_i     (regs),
    .mem_units_i(MEM_UNITS_W),
    .rd_o       (rd_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (dat_re_i) rdata_q <= rd_val;
  end

  assign dat_rdata_o = rdata_q;
  assign id_o        = regs[REG_ID];
  assign xres_o      = regs[REG_XRES];
  assign yres_o      = regs[REG_YRES];
  assign bpp_o       = regs[REG_BPP];
  assign enable_o    = regs[REG_ENABLE];
  assign bank_o      = regs[REG_BANK];
  assign virt_w_o    = regs[REG_VIRT_W];
  assign virt_h_o    = regs[REG_VIRT_H];
  assign xoff_o      = regs[REG_XOFF];
  assign yoff_o      = regs[REG_YOFF];
  assign bank_mask_o = BANK_MASK;
endmodule

// File: rtl/disp_ext_regport_chk.sv
module disp_ext_regport_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] idx_q,
  input logic        dat_we_i,
  input logic        dat_re_i,
  input logic [15:0] dat_wdata_i,
  input logic [15:0] dat_rdata_o,
  input logic [15:0] id_o,
  input logic [15:0] xres_o,
  input logic [15:0] yres_o,
  input logic [15:0] bpp_o,
  input logic [15:0] enable_o,
  input logic [15:0] bank_o,
  input logic [15:0] virt_w_o,
  input logic [15:0] virt_h_o,
  input logic [15:0] xoff_o,
  input logic [15:0] yoff_o,
  input logic [15:0] bank_mask_o
);
  logic [159:0] cfg_cat;
  assign cfg_cat = {id_o, xres_o, yres_o, bpp_o, enable_o, bank_o,
                    virt_w_o, virt_h_o, xoff_o, yoff_o};

  AST_ID_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_o >= 16'hB0C0) && (id_o <= 16'hB0C5)); // R4

  AST_HIGH_WR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_we_i && (idx_q >= 16'd10) |=> $stable(cfg_cat)); // R5

  AST_BANK_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_we_i && (idx_q == 16'd5) |=> bank_o == $past(dat_wdata_i)); // R3

  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dat_re_i |=> $stable(dat_rdata_o)); // R6

  AST_MEMSZ_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_re_i && (idx_q == 16'd10) |=> dat_rdata_o == 16'(bank_mask_o + 16'd1)); // R7

  AST_HIGH_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_re_i && (idx_q > 16'd10) |=> dat_rdata_o == 16'd0); // R8
endmodule

bind disp_ext_regport disp_ext_regport_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .idx_q      (idx_q),
  .dat_we_i   (dat_we_i),
  .dat_re_i   (dat_re_i),
  .dat_wdata_i(dat_wdata_i),
  .dat_rdata_o(dat_rdata_o),
  .id_o       (id_o),
  .xres_o     (xres_o),
  .yres_o     (yres_o),
  .bpp_o      (bpp_o),
  .enable_o   (enable_o),
  .bank_o     (bank_o),
  .virt_w_o   (virt_w_o),
  .virt_h_o   (virt_h_o),
  .xoff_o     (xoff_o),
  .yoff_o     (yoff_o),
  .bank_mask_o(bank_mask_o)
);

// File: tb/disp_ext_regport_test.sv
`timescale 1ns/1ps
module disp_ext_regport_test;
  localparam int unsigned VRAM = 32'h0040_0000;
  localparam logic [15:0] UNITS = 16'd64;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic idx_we = 1'b0, dat_we = 1'b0, dat_re = 1'b0;
  logic [15:0] idx_wd = '0, dat_wd = '0;
  logic [15:0] rdata, id, xres, yres, bpp, en, bank, vw, vh, xo, yo, bmask;

  int checks = 0;
  int errors = 0;
  logic [15:0] m [10];

  always #10 clk = ~clk;

  disp_ext_regport #(.VRAM_BYTES(VRAM)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .idx_we_i(idx_we), .idx_wdata_i(idx_wd),
    .dat_we_i(dat_we), .dat_wdata_i(dat_wd), .dat_re_i(dat_re),
    .dat_rdata_o(rdata), .id_o(id), .xres_o(xres), .yres_o(yres),
    .bpp_o(bpp), .enable_o(en), .bank_o(bank), .virt_w_o(vw),
    .virt_h_o(vh), .xoff_o(xo), .yoff_o(yo), .bank_mask_o(bmask)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_idx(input logic [15:0] v);
    @(negedge clk); idx_we = 1'b1; idx_wd = v;
    @(negedge clk); idx_we = 1'b0;
  endtask

  task automatic wr(input logic [15:0] v);
    @(negedge clk); dat_we = 1'b1; dat_wd = v;
    @(negedge clk); dat_we = 1'b0;
  endtask

  task automatic rd(output logic [15:0] v);
    @(negedge clk); dat_re = 1'b1;
    @(negedge clk); dat_re = 1'b0; v = rdata;
  endtask

  function automatic logic [15:0] exp_rd(input logic [15:0] ix);
    if (ix < 16'd10) begin
      if (m[4][1] && ix == 16'd1) return 16'd1024;
      if (m[4][1] && ix == 16'd2) return 16'd768;
      if (m[4][1] && ix == 16'd3) return 16'd32;
      return m[ix[3:0]];
    end
    if (ix == 16'd10) return UNITS;
    return 16'd0;
  endfunction

  function automatic string rd_req(input logic [15:0] ix);
    if (ix < 16'd10) return (m[4][1] && ix >= 16'd1 && ix <= 16'd3) ? "R9" : "R6";
    if (ix == 16'd10) return "R7";
    return "R8";
  endfunction

  task automatic model_wr(input logic [15:0] ix, input logic [15:0] v);
    if (ix == 16'd0) begin
      if (v >= 16'hB0C0 && v <= 16'hB0C5) m[0] = v; // R4
    end else if (ix < 16'd10) begin
      m[ix[3:0]] = v; // R3
    end // R5: others ignored
  endtask

  task automatic chk_outs(input string req);
    chk({req, " id"}, id, m[0]);     chk({req, " xres"}, xres, m[1]);
    chk({req, " yres"}, yres, m[2]); chk({req, " bpp"}, bpp, m[3]);
    chk({req, " en"}, en, m[4]);     chk({req, " bank"}, bank, m[5]);
    chk({req, " vw"}, vw, m[6]);     chk({req, " vh"}, vh, m[7]);
    chk({req, " xo"}, xo, m[8]);     chk({req, " yo"}, yo, m[9]);
  endtask

  task automatic read_all();
    logic [15:0] v;
    for (int j = 0; j < 13; j++) begin
      logic [15:0] ix;
      ix = (j == 12) ? 16'hFFFF : 16'(j);
      set_idx(ix);
      rd(v);
      chk(rd_req(ix), v, exp_rd(ix));
    end
  endtask

  initial begin
    #4_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v, held;
    for (int i = 0; i < 10; i++) m[i] = 16'h0;
    m[0] = 16'hB0C5;
    repeat (3) @(negedge clk);
    chk("R1 rdata in reset", rdata, 16'h0);
    chk("R1 id in reset", id, 16'hB0C5);
    rst_ni = 1'b1;
    @(negedge clk);
    chk_outs("R1");
    chk("R10 bank mask", bmask, UNITS - 16'd1);
    rd(v); chk("R1 index zero after reset", v, 16'hB0C5);

    // R3 R4 R5 R11 sweep: write a pattern at each index, then read everything
    for (int k = 0; k < 18; k++) begin
      logic [15:0] ix, p;
      ix = (k < 16) ? 16'(k) : ((k == 16) ? 16'h8000 : 16'hFFFF);
      p = 16'hA5C1 ^ 16'(k * 16'h0F1E);
      set_idx(ix);
      wr(p);
      model_wr(ix, p);
      chk_outs("R11");
      read_all();
    end

    // R4 identifier range edges
    set_idx(16'h0);
    wr(16'hB0C0); model_wr(16'h0, 16'hB0C0); chk("R4 id low edge", id, m[0]);
    wr(16'hB0C6); model_wr(16'h0, 16'hB0C6); chk("R4 id above range", id, m[0]);
    wr(16'hB0BF); model_wr(16'h0, 16'hB0BF); chk("R4 id below range", id, m[0]);
    wr(16'hB0C5); model_wr(16'h0, 16'hB0C5); chk("R4 id high edge", id, m[0]);

    // R9 capability mode on and off
    for (int i = 1; i < 4; i++) begin set_idx(16'(i)); wr(16'h0123 + 16'(i)); model_wr(16'(i), 16'h0123 + 16'(i)); end
    set_idx(16'd4); wr(16'h0002); model_wr(16'd4, 16'h0002);
    read_all();
    chk("R9 stored xres untouched", xres, 16'h0124);
    set_idx(16'd4); wr(16'h0001); model_wr(16'd4, 16'h0001);
    read_all();

    // R2 index and data write in same cycle: data lands at old index
    set_idx(16'd6);
    @(negedge clk); idx_we = 1'b1; idx_wd = 16'd8; dat_we = 1'b1; dat_wd = 16'h7E57;
    @(negedge clk); idx_we = 1'b0; dat_we = 1'b0;
    model_wr(16'd6, 16'h7E57);
    chk("R2 write used old index", vw, 16'h7E57);
    rd(v); chk("R2 new index selected", v, m[8]);

    // R6 hold without read strobe
    set_idx(16'd10); rd(held);
    set_idx(16'd5); wr(16'h4444); model_wr(16'd5, 16'h4444);
    repeat (3) @(negedge clk);
    chk("R6 rdata holds", rdata, held);
    chk("R7 held memsize", held, UNITS);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule